// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block decides when an SDRAM needs refreshing and then drives the command pins through the refresh sequence. A free-running prescaler produces a single-cycle tick at one of seven rates. An interval counter advances on that tick. When the counter reaches a programmed compare value, the counter returns to zero and a refresh becomes pending. The sequencer then asks the bus arbiter for the bus. Once the arbiter grants it, the sequencer runs a burst of auto-refresh operations. Each operation is a precharge-all command, an optional gap, a refresh command and an optional recovery gap.

The same enable and mode bits can instead put the memory into self-refresh. In that case the sequencer precharges all banks, issues the self-refresh entry command and keeps the bus while the memory holds its data on its own. Clearing the mode bit issues the exit command. A recovery wait follows, and then the bus is released. Software configures the block through a small write-only register port. Address 0 is control, address 1 presets the interval counter and address 2 is the compare value.

Top module: `sdram_refresh_sched`

## Requirements
- R1: Control bit 0 is enable and bit 1 is mode. Enable=1 with mode=0 selects auto-refresh, both set to 1 requests self-refresh, and enable=0 keeps the request low and the command at NOP. Clearing enable while a request is still waiting for its grant withdraws the request.
- R2: Control bits [4:2] select the counting tick. Value 0 stops the interval counter. Values 1 to 7 give one tick every 4, 16, 64, 256, 1024, 2048 and 4096 clocks.
- R3: On a tick where the counter equals the compare value (address 2), the counter clears to 0 and a refresh becomes pending. Otherwise the tick adds one. The auto-refresh interval is therefore tick period × (compare + 1) clocks. A write to address 1 presets the counter, and counting continues from that preset value.
- R4: While a refresh is pending, `arb_req_o` goes high. No command other than NOP appears until a one-cycle `arb_gnt_i` pulse arrives. The request stays high until the final recovery wait of the burst ends.
- R5: Control bits [7:5] set the number of refresh operations per burst. Codes 0, 1, 2, 3 and 4 give 1, 2, 4, 6 and 8 operations, and codes 5 to 7 give 8.
- R6: Each operation starts with a precharge-all command. The first one comes in the cycle after the grant, and each later one comes in the cycle after the previous operation's recovery.
- R7: Control bits [9:8] give the number of NOP cycles between precharge-all and refresh. A value of 0 places the two commands in adjacent cycles.
- R8: Control bits [11:10] give the number of NOP cycles after each refresh or self-refresh exit before the next command or the bus release.
- R9: A compare match that occurs during a burst is kept. The request drops for exactly one cycle after the burst and then rises again.
- R10: In self-refresh mode, the grant is followed by precharge-all and then self-refresh entry. After that, `self_ref_o` stays high with the request held. Clearing mode issues self-refresh exit, then the R8 recovery, and then the request and flag go low.
- R11: Command encoding on `sdram_cmd_o`: 0 NOP, 1 precharge-all, 2 refresh, 3 self-refresh entry, 4 self-refresh exit.
- R12: After reset, the request, the self-refresh flag and the command are all zero, and the registers are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 control, 1 counter preset, 2 compare |
| wr_data_i | input | DATA_W | Register write data |
| arb_gnt_i | input | 1 | One-cycle bus grant from the arbiter |
| arb_req_o | output | 1 | Bus request, held for the whole refresh activity |
| sdram_cmd_o | output | 3 | SDRAM command code (R11) |
| self_ref_o | output | 1 | High while the memory is in self-refresh |

## Verification
The bench records the full command stream of each burst and compares it with a sequence built from the repeat, gap and recovery settings. The settings include zero gaps and repeat codes above 4. A design that miscounts the gaps, or that treats codes 5 to 7 literally, produces a stream of the wrong length or order. The interval is measured between consecutive requests at two tick rates, so an off-by-one compare shows up as a gap four or sixteen clocks off. Other cases covered are a preset counter, a stopped tick, a disabled block and a match during a long burst; a design that drops such a match never raises its second request. Self-refresh entry and exit are checked for flag timing and for the exit recovery.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

   typedef enum logic [2:0] {
      CMD_NOP      = 3'd0,
      CMD_PALL     = 3'd1,
      CMD_REF      = 3'd2,
      CMD_SREF_IN  = 3'd3,
      CMD_SREF_OUT = 3'd4
   } sd_cmd_e;

   typedef struct packed {
      logic [1:0] trc;
      logic [1:0] trp;
      logic [2:0] rep;
      logic [2:0] csel;
      logic       self_mode;
      logic       enable;
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);
   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_CNT  = 2'd1;
   localparam logic [1:0] ADDR_CMP  = 2'd2;

   // log2 of the prescaler divisor for each nonzero clock-select code
   function automatic int unsigned div_log2(input int unsigned sel);
      case (sel)
         1: return 2;
         2: return 4;
         3: return 6;
         4: return 8;
         5: return 10;
         6: return 11;
         default: return 12;
      endcase
   endfunction

   function automatic logic [3:0] burst_len(input logic [2:0] code);
      case (code)
         3'd0: return 4'd1;
         3'd1: return 4'd2;
         3'd2: return 4'd4;
         3'd3: return 4'd6;
         default: return 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/rfsh_regs.sv
module rfsh_regs
   import rfsh_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output ctrl_t             ctrl,
   output logic [CNT_W-1:0]  cmp_val,
   output logic              cnt_load,
   output logic [CNT_W-1:0]  cnt_load_val
);

   generate
      if (DATA_W < CTRL_W || DATA_W < CNT_W) begin : g_bad_width
         $error("rfsh_regs: DATA_W must cover control and counter fields");
      end
   endgenerate

   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl    <= '0;
         cmp_val <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_CTRL) ctrl    <= ctrl_t'(wr_data[CTRL_W-1:0]);
         if (wr_addr == ADDR_CMP)  cmp_val <= wr_data[CNT_W-1:0];
      end
   end

   assign cnt_load     = wr_en && (wr_addr == ADDR_CNT);
   assign cnt_load_val = wr_data[CNT_W-1:0];

endmodule

// File: rtl/rfsh_prescaler.sv
module rfsh_prescaler
   import rfsh_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] csel,
   output logic       tick
);

   localparam int unsigned PRE_W = div_log2(7);

   logic [PRE_W-1:0] presc;
   logic [7:0]       sel_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) presc <= '0;
      else        presc <= presc + 1'b1;
   end

   assign sel_tick[0] = 1'b0;
   generate
      for (genvar g = 1; g < 8; g++) begin : g_rate
         localparam int unsigned LG = div_log2(g);
         assign sel_tick[g] = &presc[LG-1:0];
      end
   endgenerate

   assign tick = sel_tick[csel];

endmodule

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] cmp_val,
   output logic             match
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         match <= 1'b0;
      end else begin
         match <= 1'b0;
         if (load) begin
            cnt <= load_val;
         end else if (tick) begin
            if (cnt == cmp_val) begin
               cnt   <= '0;
               match <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
   import rfsh_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic       self_mode,
   input  logic [2:0] rep,
   input  logic [1:0] trp,
   input  logic [1:0] trc,
   input  logic       match,
   input  logic       gnt,
   output logic       req,
   output sd_cmd_e    cmd,
   output logic       self_active
);

   typedef enum logic [3:0] {
      S_IDLE, S_REQ, S_PALL, S_TRP, S_REF, S_TRC, S_SR_IN, S_SR_HOLD, S_SR_OUT
   } st_e;

   st_e        state;
   logic [1:0] wcnt;
   logic [3:0] left;
   logic       is_self;
   logic       pending;
   logic       auto_on, self_on, take;

   assign auto_on = enable & ~self_mode;
   assign self_on = enable & self_mode;
   assign take    = (state == S_IDLE) && pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pending <= 1'b0;
      else if (!auto_on) pending <= 1'b0;
      else if (match)    pending <= 1'b1;
      else if (take)     pending <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         wcnt    <= '0;
         left    <= '0;
         is_self <= 1'b0;
      end else begin
         case (state)
            S_IDLE: if (self_on || (auto_on && pending)) state <= S_REQ;
            S_REQ: begin
               if (!enable) begin
                  state <= S_IDLE;
               end else if (gnt) begin
                  is_self <= self_mode;
                  left    <= burst_len(rep);
                  state   <= S_PALL;
               end
            end
            S_PALL: begin
               if (is_self) state <= S_SR_IN;
               else if (trp != 2'd0) begin
                  wcnt  <= trp;
                  state <= S_TRP;
               end else state <= S_REF;
            end
            S_TRP: begin
               if (wcnt == 2'd1) state <= S_REF;
               else wcnt <= wcnt - 2'd1;
            end
            S_REF: begin
               left <= left - 4'd1;
               if (trc != 2'd0) begin
                  wcnt  <= trc;
                  state <= S_TRC;
               end else if (left == 4'd1) state <= S_IDLE;
               else state <= S_PALL;
            end
            S_TRC: begin
               if (wcnt == 2'd1) state <= (left == 4'd0) ? S_IDLE : S_PALL;
               else wcnt <= wcnt - 2'd1;
            end
            S_SR_IN:   state <= S_SR_HOLD;
            S_SR_HOLD: if (!self_on) state <= S_SR_OUT;
            S_SR_OUT: begin
               left <= '0;
               if (trc != 2'd0) begin
                  wcnt  <= trc;
                  state <= S_TRC;
               end else state <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      case (state)
         S_PALL:   cmd = CMD_PALL;
         S_REF:    cmd = CMD_REF;
         S_SR_IN:  cmd = CMD_SREF_IN;
         S_SR_OUT: cmd = CMD_SREF_OUT;
         default:  cmd = CMD_NOP;
      endcase
   end

   assign req         = (state != S_IDLE);
   assign self_active = (state == S_SR_HOLD);

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
   import rfsh_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              arb_gnt_i,
   output logic              arb_req_o,
   output logic [2:0]        sdram_cmd_o,
   output logic              self_ref_o
);

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("sdram_refresh_sched: CNT_W must be at least 2");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] cmp_val, load_val;
   logic             cnt_load, tick, match;
   sd_cmd_e          cmd;

   rfsh_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
      .wr_data(wr_data_i), .ctrl(ctrl_q), .cmp_val(cmp_val),
      .cnt_load(cnt_load), .cnt_load_val(load_val)
   );

   rfsh_prescaler u_presc (
      .clk(clk), .rst_n(rst_n), .csel(ctrl_q.csel), .tick(tick)
   );

   rfsh_interval #(.CNT_W(CNT_W)) u_intv (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_load),
      .load_val(load_val), .cmp_val(cmp_val), .match(match)
   );

   rfsh_seq u_seq (
      .clk(clk), .rst_n(rst_n), .enable(ctrl_q.enable),
      .self_mode(ctrl_q.self_mode), .rep(ctrl_q.rep), .trp(ctrl_q.trp),
      .trc(ctrl_q.trc), .match(match), .gnt(arb_gnt_i), .req(arb_req_o),
      .cmd(cmd), .self_active(self_ref_o)
   );

   assign sdram_cmd_o = cmd;

endmodule

// File: rtl/rfsh_chk.sv
module rfsh_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       arb_req_o,
   input logic [2:0] sdram_cmd_o,
   input logic       self_ref_o,
   input logic [1:0] trp,
   input logic [1:0] trc,
   input logic       self_mode
);

   // R4
   req_rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arb_req_o) |-> sdram_cmd_o == 3'd0);

   // R7
   pall_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sdram_cmd_o == 3'd1 && trp != 2'd0 && !self_mode) |=> sdram_cmd_o == 3'd0);

   // R8
   ref_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sdram_cmd_o == 3'd2 && trc != 2'd0) |=> sdram_cmd_o == 3'd0);

   // R6
   no_double_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sdram_cmd_o == 3'd2) |=> sdram_cmd_o != 3'd2);

   // R10
   sref_enter_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sdram_cmd_o == 3'd3) |=> self_ref_o);

   // R10
   sref_exit_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(self_ref_o) |-> sdram_cmd_o == 3'd4);

   // R10
   sref_holds_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      self_ref_o |-> arb_req_o);

endmodule

bind sdram_refresh_sched rfsh_chk u_chk (
   .clk(clk), .rst_n(rst_n), .arb_req_o(arb_req_o), .sdram_cmd_o(sdram_cmd_o),
   .self_ref_o(self_ref_o), .trp(ctrl_q.trp), .trc(ctrl_q.trc),
   .self_mode(ctrl_q.self_mode)
);

// File: tb/sdram_refresh_sched_tb.sv
module sdram_refresh_sched_tb;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        gnt = 1'b0;
   logic        req;
   logic [2:0]  cmd;
   logic        self_o;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   logic [2:0] got [0:255];
   logic [2:0] exp_s [0:255];
   int ng;

   always #(CLK_P/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sdram_refresh_sched u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .arb_gnt_i(gnt), .arb_req_o(req),
      .sdram_cmd_o(cmd), .self_ref_o(self_o)
   );

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   function automatic logic [15:0] mk(input int en, input int md, input int sel,
                                      input int rep, input int trp, input int trc);
      logic [15:0] v;
      v = '0;
      v[0] = en[0]; v[1] = md[0]; v[4:2] = sel[2:0];
      v[7:5] = rep[2:0]; v[9:8] = trp[1:0]; v[11:10] = trc[1:0];
      return v;
   endfunction

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_req(input int lim, output bit seen);
      seen = 1'b0;
      for (int i = 0; i < lim; i++) begin
         if (req) begin seen = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   task automatic grant_pulse();
      gnt = 1'b1;
      @(negedge clk);
      gnt = 1'b0;
   endtask

   task automatic capture();
      ng = 0;
      while (req && ng < 256) begin
         got[ng] = cmd;
         ng++;
         @(negedge clk);
      end
   endtask

   task automatic quiesce();
      wr(2'd0, 16'h0000);
      repeat (3) @(negedge clk);
      chk(req == 1'b0, "R1 request withdrawn after disable", req, 0);
   endtask

   task automatic t_reset();
      chk(req == 1'b0 && cmd == 3'd0 && self_o == 1'b0, "R12 reset outputs",
          {req, self_o, cmd}, 0);
   endtask

   task automatic t_burst(input int code, input int trp, input int trc, input int n);
      bit seen;
      int e, bad;
      wr(2'd0, 16'h0000);
      wr(2'd2, 16'd3);
      wr(2'd1, 16'd0);
      wr(2'd0, mk(1, 0, 1, code, trp, trc));
      wait_req(200, seen);
      chk(seen, "R4 request raised on match", seen, 1);
      bad = 0;
      for (int i = 0; i < 3; i++) begin
         if (cmd != 3'd0 || !req) bad++;
         @(negedge clk);
      end
      chk(bad == 0, "R4 NOP while waiting for grant", bad, 0);
      grant_pulse();
      capture();
      e = 0;
      for (int op = 0; op < n; op++) begin
         exp_s[e++] = 3'd1;
         for (int t = 0; t < trp; t++) exp_s[e++] = 3'd0;
         exp_s[e++] = 3'd2;
         for (int t = 0; t < trc; t++) exp_s[e++] = 3'd0;
      end
      chk(ng == e, "R5 burst length", ng, e);
      bad = 0;
      for (int i = 0; i < e && i < ng; i++) if (got[i] != exp_s[i]) bad++;
      chk(bad == 0, "R6 R7 R8 R11 command order and gaps", bad, 0);
      quiesce();
   endtask

   task automatic t_interval(input int sel, input int cmp, input int gap);
      bit seen;
      int t1, t2;
      wr(2'd0, 16'h0000);
      wr(2'd2, cmp[15:0]);
      wr(2'd1, 16'd0);
      wr(2'd0, mk(1, 0, sel, 0, 0, 0));
      wait_req(20000, seen);
      t1 = cyc;
      grant_pulse();
      while (req) @(negedge clk);
      wait_req(20000, seen);
      t2 = cyc;
      chk(seen && (t2 - t1) == gap, "R2 R3 refresh interval", t2 - t1, gap);
      grant_pulse();
      quiesce();
   endtask

   task automatic t_preload();
      bit seen;
      wr(2'd0, 16'h0000);
      wr(2'd2, 16'd20);
      wr(2'd1, 16'd20);
      wr(2'd0, mk(1, 0, 1, 0, 0, 0));
      wait_req(8, seen);
      chk(seen, "R3 preset counter matches at first tick", seen, 1);
      quiesce();
   endtask

   task automatic t_stopped();
      int bad;
      wr(2'd0, 16'h0000);
      wr(2'd2, 16'd0);
      wr(2'd1, 16'd0);
      wr(2'd0, mk(1, 0, 0, 0, 0, 0));
      bad = 0;
      for (int i = 0; i < 300; i++) begin
         if (req) bad++;
         @(negedge clk);
      end
      chk(bad == 0, "R2 select 0 stops counting", bad, 0);
      wr(2'd0, mk(0, 0, 1, 0, 0, 0));
      bad = 0;
      for (int i = 0; i < 100; i++) begin
         if (req || cmd != 3'd0) bad++;
         @(negedge clk);
      end
      chk(bad == 0, "R1 disabled block stays quiet", bad, 0);
      quiesce();
   endtask

   task automatic t_pending();
      bit seen;
      wr(2'd0, 16'h0000);
      wr(2'd2, 16'd1);
      wr(2'd1, 16'd0);
      wr(2'd0, mk(1, 0, 1, 4, 3, 3));
      wait_req(100, seen);
      grant_pulse();
      while (req) @(negedge clk);
      @(negedge clk);
      chk(req == 1'b1, "R9 match during burst served after one idle cycle", req, 1);
      quiesce();
   endtask

   task automatic t_self();
      bit seen;
      int bad;
      wr(2'd0, 16'h0000);
      wr(2'd0, mk(1, 1, 0, 0, 0, 2));
      wait_req(10, seen);
      chk(seen, "R10 self-refresh requests bus", seen, 1);
      grant_pulse();
      chk(cmd == 3'd1, "R10 precharge-all before entry", cmd, 1);
      @(negedge clk);
      chk(cmd == 3'd3, "R10 R11 self-refresh entry command", cmd, 3);
      @(negedge clk);
      bad = 0;
      for (int i = 0; i < 10; i++) begin
         if (!self_o || !req || cmd != 3'd0) bad++;
         @(negedge clk);
      end
      chk(bad == 0, "R10 flag and bus held in self-refresh", bad, 0);
      wr(2'd0, mk(1, 0, 0, 0, 0, 2));
      ng = 0;
      while (req && ng < 64) begin
         if (!self_o) begin got[ng] = cmd; ng++; end
         @(negedge clk);
      end
      chk(ng == 3 && got[0] == 3'd4 && got[1] == 3'd0 && got[2] == 3'd0,
          "R10 R8 exit then recovery", ng, 3);
      chk(self_o == 1'b0, "R10 flag low after exit", self_o, 0);
      quiesce();
   endtask

   initial begin
      #(CLK_P * 150000);
      n_fail++;
      $display("FAIL R4 watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_burst(0, 0, 0, 1);
      t_burst(1, 1, 2, 2);
      t_burst(2, 3, 0, 4);
      t_burst(3, 2, 1, 6);
      t_burst(4, 0, 3, 8);
      t_burst(7, 1, 1, 8);
      t_interval(1, 9, 40);
      t_interval(2, 2, 48);
      t_preload();
      t_stopped();
      t_pending();
      t_self();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule